// File: doc/BRIEF.md
# SMBus Indexed Register Slave

This block is an SMBus slave that gives a bus master access to a byte-wide control register file. It answers on bus address D2h for writes and D3h for reads. The register file sits outside the block and is reached through a one-cycle write strobe and a combinational read port. The block itself holds one register, the stored read length. It sits at index 8, and every read transfer takes its length from it.

Three transfers are supported. An indexed block write sends a starting offset, a byte count and then that many data bytes. An indexed read sends an offset, then a repeated start with the read address, and the slave returns the stored length followed by that many register bytes. The third is a combined transfer. Here the count byte of a write carries a flag in its top bit, so its low seven bits replace the stored length, and the master follows at once with a repeated start and a read.

SCL and SDA arrive already synchronised to the system clock. The slave pulls SDA low through a pull-down enable, and it never stretches the clock.

Top module: `smb_idx_regs`

## Requirements
- R1: Only the address bytes D2h (write) and D3h (read) are acknowledged. Any other address byte gets no acknowledge, and every bit that follows is ignored (no acknowledge, no register write) until the next start.
- R2: In a write transfer, the slave acknowledges the offset byte, a count byte N with bit 7 clear (1 to 127), and N data bytes. Each data byte produces exactly one write strobe carrying the current offset and the byte, and the offset then advances by one, wrapping at 8 bits.
- R3: A count byte of 00h is not acknowledged and the transfer is dropped. A data byte beyond the N announced is not acknowledged and is not written.
- R4: A count byte with bit 7 set is acknowledged. Its bits 6:0 become the stored read length, no data is written, and a following repeated start with D3h reads from the offset just sent.
- R5: After D3h, the slave sends the stored length as the first byte, then the registers at offset, offset+1, … for the stored length, MSB first. If the master acknowledges the last byte, the slave sends nothing further and SDA stays released.
- R6: A master NACK on any read byte ends the transfer, and the slave releases SDA for the rest of it.
- R7: The stored read length resets to 0Fh. It is read at index 8 with bit 7 as 0, in place of the external read data. A block write to index 8 loads the length from data bits 6:0 and also produces the normal write strobe.
- R8: A combined transfer with count byte 81h returns exactly one data byte, and a later read of index 8 returns 01h.
- R9: A start or stop in the middle of a byte aborts the transfer and releases SDA. Writes strobed before it are kept, and a following transfer works normally.
- R10: A stored length of 0 is sent as 00h in the count byte but reads one data byte.
- R11: The slave only begins pulling SDA low while SCL is low.
- R12: The write strobe is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired line) |
| sda_pd_o | output | 1 | 1 pulls SDA low |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register index written |
| wr_data_o | output | 8 | Byte written |
| rd_addr_o | output | 8 | Register index being fetched for reading |
| rd_data_i | input | 8 | External register value at rd_addr_o, same cycle |

## Verification
Two functions can fall in the same cycle: the external write strobe, and the load of the internal read length. This happens when a block write crosses index 8. The bench provokes it with a two-byte write starting at index 7. It judges the outcome from both sides: the write port must carry both bytes in order, and a following read of index 8 must return the new length in the count byte and in the first data byte, with bit 7 cleared.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 7;

    localparam logic [BYTE_W-1:0] ADDR_WR = 8'hD2;
    localparam logic [BYTE_W-1:0] ADDR_RD = 8'hD3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_OFFS,
        ST_CNT,
        ST_WDATA,
        ST_TXCNT,
        ST_TXDATA
    } xfer_st_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // a zero length still reads one byte so the sequence terminates
    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction

endpackage

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import smb_idx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = scl_i & ~scl_q;
        ev.scl_fall = ~scl_i & scl_q;
        ev.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/smb_rdcnt_reg.sv
module smb_rdcnt_reg #(
    parameter int                CW        = 7,
    parameter logic [CW-1:0]     RESET_VAL = 7'h0F
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flag_ld,
    input  logic          reg_ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RESET_VAL;
        end else if (flag_ld || reg_ld) begin
            cnt <= ld_val;
        end
    end

endmodule

// File: rtl/smb_xfer_ctrl.sv
module smb_xfer_ctrl
    import smb_idx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CNT_IDX = 8'd8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              sda_i,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] rd_addr_o,
    output logic              drive_o,
    output wr_req_t           wr_o,
    output logic              flag_ld_o,
    output logic              reg_ld_o,
    output logic [CNT_W-1:0]  ld_val_o
);

    localparam logic [3:0] BIT_LAST = 4'd8;
    localparam logic [3:0] BIT_ACK  = 4'd9;

    xfer_st_t          st;
    xfer_st_t          nxt;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rem;
    logic              drive_q;
    wr_req_t           wr_q;
    logic              flag_ld_q;
    logic              reg_ld_q;
    logic [CNT_W-1:0]  ld_val_q;

    logic              is_tx;
    logic [BYTE_W-1:0] rd_byte;

    assign is_tx     = (st == ST_TXCNT) || (st == ST_TXDATA);
    assign rd_byte   = (ptr == CNT_IDX) ? {1'b0, cnt} : rd_data_i;
    assign rd_addr_o = ptr;
    assign drive_o   = drive_q;
    assign wr_o      = wr_q;
    assign flag_ld_o = flag_ld_q;
    assign reg_ld_o  = reg_ld_q;
    assign ld_val_o  = ld_val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            nxt       <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            ptr       <= '0;
            rem       <= '0;
            drive_q   <= 1'b0;
            wr_q      <= '0;
            flag_ld_q <= 1'b0;
            reg_ld_q  <= 1'b0;
            ld_val_q  <= '0;
        end else begin
            wr_q.en   <= 1'b0;
            flag_ld_q <= 1'b0;
            reg_ld_q  <= 1'b0;
            if (ev.start) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                drive_q <= 1'b0;
            end else if (ev.stop) begin
                st      <= ST_IDLE;
                bit_cnt <= '0;
                drive_q <= 1'b0;
            end else if (st != ST_IDLE) begin
                if (ev.scl_rise) begin
                    if (is_tx) begin
                        if (bit_cnt == BIT_LAST) begin
                            if (sda_i) begin
                                st      <= ST_IDLE;
                                bit_cnt <= '0;
                            end else begin
                                bit_cnt <= BIT_ACK;
                            end
                        end else if (bit_cnt < BIT_LAST) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end else if (bit_cnt < BIT_LAST) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end else if (ev.scl_fall) begin
                    if (bit_cnt == BIT_ACK) begin
                        bit_cnt <= '0;
                        case (st)
                            ST_TXCNT: begin
                                shreg   <= rd_byte;
                                drive_q <= ~rd_byte[BYTE_W-1];
                                ptr     <= ptr + 8'd1;
                                rem     <= {1'b0, eff_len(cnt)} - 8'd1;
                                st      <= ST_TXDATA;
                            end
                            ST_TXDATA: begin
                                if (rem == '0) begin
                                    drive_q <= 1'b0;
                                    st      <= ST_IDLE;
                                end else begin
                                    shreg   <= rd_byte;
                                    drive_q <= ~rd_byte[BYTE_W-1];
                                    ptr     <= ptr + 8'd1;
                                    rem     <= rem - 8'd1;
                                end
                            end
                            default: begin
                                st <= nxt;
                                if (nxt == ST_TXCNT) begin
                                    shreg   <= {1'b0, cnt};
                                    drive_q <= 1'b1;
                                end else begin
                                    drive_q <= 1'b0;
                                end
                            end
                        endcase
                    end else if (is_tx) begin
                        if (bit_cnt == BIT_LAST) begin
                            drive_q <= 1'b0;
                        end else if (bit_cnt != '0) begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            drive_q <= ~shreg[BYTE_W-2];
                        end
                    end else if (bit_cnt == BIT_LAST) begin
                        // a received byte is complete: acknowledge or drop
                        case (st)
                            ST_ADDR: begin
                                if (shreg == ADDR_WR || shreg == ADDR_RD) begin
                                    drive_q <= 1'b1;
                                    bit_cnt <= BIT_ACK;
                                    nxt     <= (shreg == ADDR_RD) ? ST_TXCNT : ST_OFFS;
                                end else begin
                                    st      <= ST_IDLE;
                                    bit_cnt <= '0;
                                end
                            end
                            ST_OFFS: begin
                                drive_q <= 1'b1;
                                bit_cnt <= BIT_ACK;
                                ptr     <= shreg;
                                nxt     <= ST_CNT;
                            end
                            ST_CNT: begin
                                if (shreg == '0) begin
                                    st      <= ST_IDLE;
                                    bit_cnt <= '0;
                                end else begin
                                    drive_q <= 1'b1;
                                    bit_cnt <= BIT_ACK;
                                    if (shreg[BYTE_W-1]) begin
                                        flag_ld_q <= 1'b1;
                                        ld_val_q  <= shreg[CNT_W-1:0];
                                        nxt       <= ST_IDLE;
                                    end else begin
                                        rem <= shreg;
                                        nxt <= ST_WDATA;
                                    end
                                end
                            end
                            ST_WDATA: begin
                                drive_q   <= 1'b1;
                                bit_cnt   <= BIT_ACK;
                                wr_q.en   <= 1'b1;
                                wr_q.addr <= ptr;
                                wr_q.data <= shreg;
                                if (ptr == CNT_IDX) begin
                                    reg_ld_q <= 1'b1;
                                    ld_val_q <= shreg[CNT_W-1:0];
                                end
                                ptr <= ptr + 8'd1;
                                rem <= rem - 8'd1;
                                nxt <= (rem == 8'd1) ? ST_IDLE : ST_WDATA;
                            end
                            default: begin
                                st      <= ST_IDLE;
                                bit_cnt <= '0;
                            end
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs
    import smb_idx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CNT_IDX   = 8'd8,
    parameter logic [CNT_W-1:0]  CNT_RESET = 7'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pd_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [BYTE_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);

    bus_ev_t          ev;
    wr_req_t          wr;
    logic [CNT_W-1:0] cnt;
    logic             flag_ld;
    logic             reg_ld;
    logic [CNT_W-1:0] ld_val;

    smb_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_rdcnt_reg #(
        .CW        (CNT_W),
        .RESET_VAL (CNT_RESET)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .flag_ld (flag_ld),
        .reg_ld  (reg_ld),
        .ld_val  (ld_val),
        .cnt     (cnt)
    );

    smb_xfer_ctrl #(
        .CNT_IDX (CNT_IDX)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_i     (sda_i),
        .cnt       (cnt),
        .rd_data_i (rd_data_i),
        .rd_addr_o (rd_addr_o),
        .drive_o   (sda_pd_o),
        .wr_o      (wr),
        .flag_ld_o (flag_ld),
        .reg_ld_o  (reg_ld),
        .ld_val_o  (ld_val)
    );

    assign wr_en_o   = wr.en;
    assign wr_addr_o = wr.addr;
    assign wr_data_o = wr.data;

endmodule

// File: rtl/smb_idx_regs_chk.sv
module smb_idx_regs_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_i,
    input logic sda_pd_o,
    input logic wr_en_o
);

    // R11: the pull-down only engages while SCL is low
    p_pd_rise_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pd_o) |-> !scl_i);

    // R12: the write strobe never lasts two cycles
    p_wr_single_r12: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);

    // R2: a register write is always paired with an acknowledge
    p_wr_with_ack_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> sda_pd_o);

    // R9: a stop releases the line
    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && $rose(sda_i)) |=> !sda_pd_o);

    // R9: a start releases the line
    p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && $fell(sda_i)) |=> !sda_pd_o);

endmodule

bind smb_idx_regs smb_idx_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_pd_o (sda_pd_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/tb_smb_idx_regs.sv
module tb_smb_idx_regs;

    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       scl   = 1'b1;
    logic       sda_m = 1'b1;
    wire        sda_pd;
    wire        sda_line = sda_m & ~sda_pd;
    wire        wr_en;
    wire  [7:0] wr_addr;
    wire  [7:0] wr_data;
    wire  [7:0] rd_addr;
    wire  [7:0] rd_data;

    logic [7:0] ext_mem [256];
    logic [7:0] exp_mem [256];
    int         exp_cnt = 15;
    logic [15:0] exp_wq [$];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit prev_pd = 0;
    bit prev_wr = 0;

    assign rd_data = ext_mem[rd_addr];

    smb_idx_regs dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_pd_o  (sda_pd),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        return (a == 8'd8) ? 8'(exp_cnt) : exp_mem[a];
    endfunction

    // the bench owns the register file that the write port updates
    always @(posedge clk) begin
        if (wr_en) ext_mem[wr_addr] = wr_data;
    end

    // per-clock comparison against the expected write stream
    always @(negedge clk) begin
        logic [15:0] e;
        if (!rst) begin
            if (wr_en) begin
                if (exp_wq.size() == 0) begin
                    check(1'b0, "R3 unexpected write", {wr_addr, wr_data}, 0);
                end else begin
                    e = exp_wq.pop_front();
                    check({wr_addr, wr_data} == e, "R2 write port", {wr_addr, wr_data}, e);
                end
                check(!prev_wr, "R12 strobe width", 2, 1);
            end
            if (sda_pd && !prev_pd) check(!scl, "R11 pull-down start while SCL high", scl, 0);
            prev_pd = sda_pd;
            prev_wr = wr_en;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = !sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic m_recv(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0;
        end
        tick(Q);
        sda_m = mack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic read_body(input logic [7:0] off, input string tag);
        logic [7:0] b;
        int n;
        m_recv(1'b1, b);
        check(b == 8'(exp_cnt), {tag, " count byte"}, b, exp_cnt);
        n = (exp_cnt == 0) ? 1 : exp_cnt;
        for (int k = 0; k < n; k++) begin
            m_recv(k != n - 1, b);
            check(b == exp_byte(off + 8'(k)), {tag, " data byte"}, b, exp_byte(off + 8'(k)));
        end
        m_stop();
        check(sda_pd == 1'b0, {tag, " released after read"}, sda_pd, 0);
    endtask

    task automatic idx_read(input logic [7:0] off, input string tag);
        bit a;
        m_start();
        m_send(8'hD2, a); check(a, {tag, " ack D2"}, a, 1);
        m_send(off, a);   check(a, {tag, " ack offset"}, a, 1);
        m_start();
        m_send(8'hD3, a); check(a, {tag, " ack D3"}, a, 1);
        read_body(off, tag);
    endtask

    task automatic comb_read(input logic [7:0] off, input logic [7:0] cb, input string tag);
        bit a;
        m_start();
        m_send(8'hD2, a); check(a, {tag, " ack D2"}, a, 1);
        m_send(off, a);   check(a, {tag, " ack offset"}, a, 1);
        m_send(cb, a);    check(a, {tag, " ack flagged count"}, a, 1);
        exp_cnt = int'(cb[6:0]);
        m_start();
        m_send(8'hD3, a); check(a, {tag, " ack D3"}, a, 1);
        read_body(off, tag);
    endtask

    task automatic blk_write(input logic [7:0] off, input logic [7:0] d[$], input string tag);
        bit a;
        logic [7:0] p;
        p = off;
        m_start();
        m_send(8'hD2, a);        check(a, {tag, " ack D2"}, a, 1);
        m_send(off, a);          check(a, {tag, " ack offset"}, a, 1);
        m_send(8'(d.size()), a); check(a, {tag, " ack count"}, a, 1);
        foreach (d[i]) begin
            exp_wq.push_back({p, d[i]});
            exp_mem[p] = d[i];
            if (p == 8'd8) exp_cnt = int'(d[i][6:0]);
            m_send(d[i], a); check(a, {tag, " ack data"}, a, 1);
            p = p + 8'd1;
        end
        m_stop();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) begin
            ext_mem[i] = 8'(i * 37 + 11);
            exp_mem[i] = 8'(i * 37 + 11);
        end
        rst = 1'b1; tick(5);
        rst = 1'b0; tick(2);

        // R7 reset state
        check(sda_pd == 1'b0, "R7 reset SDA released", sda_pd, 0);
        check(wr_en == 1'b0, "R7 reset no write", wr_en, 0);
        idx_read(8'd8, "R7 reset length");

        // R2 block write, R4/R5 read back through combined transfer
        blk_write(8'h20, '{8'hA5, 8'h5A, 8'hF0}, "R2 write three");
        comb_read(8'h20, 8'h83, "R4 combined read three");

        // R8 one-byte combined read
        comb_read(8'h21, 8'h81, "R8 flag 81h");
        idx_read(8'd8, "R8 length now 01h");

        // R1 foreign address
        m_start();
        m_send(8'hA0, a); check(!a, "R1 foreign address nack", a, 0);
        m_send(8'h55, a); check(!a, "R1 bytes after foreign address ignored", a, 0);
        m_stop();
        check(exp_wq.size() == 0, "R1 no write pending", exp_wq.size(), 0);

        // R3 zero count and surplus data
        m_start();
        m_send(8'hD2, a); m_send(8'h50, a);
        m_send(8'h00, a); check(!a, "R3 zero count nack", a, 0);
        m_stop();
        m_start();
        m_send(8'hD2, a); m_send(8'h51, a);
        m_send(8'h01, a); check(a, "R3 count one ack", a, 1);
        exp_wq.push_back({8'h51, 8'h11}); exp_mem[8'h51] = 8'h11;
        m_send(8'h11, a); check(a, "R3 first data ack", a, 1);
        m_send(8'h22, a); check(!a, "R3 surplus data nack", a, 0);
        m_stop();

        // R7 write crossing index 8: strobe and length load together
        blk_write(8'd7, '{8'h3C, 8'h85}, "R7 write across index 8");
        idx_read(8'd8, "R7 length via index 8");

        // R10 zero length, R5 silence after an acknowledged last byte
        blk_write(8'd8, '{8'h00}, "R10 set length zero");
        m_start();
        m_send(8'hD2, a); m_send(8'h30, a);
        m_start();
        m_send(8'hD3, a); check(a, "R10 ack D3", a, 1);
        m_recv(1'b1, b); check(b == 8'h00, "R10 count byte zero", b, 0);
        m_recv(1'b1, b); check(b == exp_mem[8'h30], "R10 single data byte", b, exp_mem[8'h30]);
        m_recv(1'b0, b); check(b == 8'hFF, "R5 no byte beyond length", b, 8'hFF);
        m_stop();

        // R9 stop inside a data byte
        m_start();
        m_send(8'hD2, a); m_send(8'h40, a); m_send(8'h02, a);
        exp_wq.push_back({8'h40, 8'h5A}); exp_mem[8'h40] = 8'h5A;
        m_send(8'h5A, a); check(a, "R9 first byte ack", a, 1);
        for (int i = 7; i >= 4; i--) begin
            sda_m = i[0]; tick(Q);
            scl = 1'b1; tick(2 * Q);
            scl = 1'b0; tick(Q);
        end
        m_stop();
        check(sda_pd == 1'b0, "R9 released after abort", sda_pd, 0);
        check(exp_wq.size() == 0, "R9 partial byte not written", exp_wq.size(), 0);
        comb_read(8'h40, 8'h82, "R9 committed byte kept");

        // R6 early NACK
        m_start();
        m_send(8'hD2, a); m_send(8'h20, a); m_send(8'h83, a);
        exp_cnt = 3;
        m_start();
        m_send(8'hD3, a);
        m_recv(1'b1, b); check(b == 8'h03, "R6 count byte", b, 3);
        m_recv(1'b0, b); check(b == exp_mem[8'h20], "R6 first byte", b, exp_mem[8'h20]);
        tick(2);
        check(sda_pd == 1'b0, "R6 released after NACK", sda_pd, 0);
        m_recv(1'b0, b); check(b == 8'hFF, "R6 silent after NACK", b, 8'hFF);
        m_stop();

        tick(10);
        check(exp_wq.size() == 0, "R2 all expected writes seen", exp_wq.size(), 0);
        done = 1;
        finish_run();
    end

endmodule